// File: doc/BRIEF.md
# Soft-Reset Control Register with Set/Clear Aliases

This block holds a single 32-bit control word for a peripheral. The top bit requests a soft reset of the peripheral and the next bit gates its clock. The remaining 30 bits are ordinary storage. Software reaches the word through three write addresses on a simple memory-mapped bus. One address replaces the whole word. A second ORs the write data into it. A third clears the bits that are 1 in the write data. Because of the two alias addresses, single bits can be changed without a read-modify-write.

When the soft-reset bit goes to 1, the block holds its module reset output active and clears its other storage. After a fixed drain time it sets the clock-gate bit by itself, so software can poll the word and see that the reset has taken hold. To bring the peripheral back, software clears the soft-reset bit and then the clock-gate bit. The clock-enable and module-reset outputs drive the peripheral's datapath.

Top module: `srst_ctrl_reg`

## Requirements
- R1: After the bus reset `rstN` is released, the word reads 0x00000000, `clkEnable` is 1 and `modReset` is 0.
- R2: A write to byte offset 0x0 replaces the whole word with the write data.
- R3: A write to offset 0x4 sets exactly the bits that are 1 in the write data and leaves every other bit unchanged.
- R4: A write to offset 0x8 clears exactly the bits that are 1 in the write data and leaves every other bit unchanged.
- R5: A write to any other offset, such as 0xC, leaves the word unchanged.
- R6: Bit 31 is the soft-reset bit and drives `modReset`. While it reads 1, bits 29:0 read 0, and any data written to them does not stick.
- R7: Bit 30 is the clock-gate bit. The hardware sets it on the DRAIN_CYCLES-th rising clock edge after the edge that made bit 31 equal to 1 (default 4), and not earlier. While bit 31 stays 1 after that, the hardware keeps bit 30 at 1.
- R8: `clkEnable` is always the inverse of bit 30 of the word.
- R9: Clearing bit 31 and then bit 30 returns the block to running: both bits read 0, `modReset` is 0 and `clkEnable` is 1. Setting bit 31 again restarts the full drain time.
- R10: `busRdata` always shows the current control word, whatever the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous bus reset |
| busWe | input | 1 | Write strobe, one cycle per write |
| busAddr | input | 4 | Byte offset of the write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Current control word |
| clkEnable | output | 1 | Clock enable for the peripheral, low while gated |
| modReset | output | 1 | Module reset for the peripheral, high while soft reset is held |

## Verification
The assertions check these properties on every cycle:
- The write strobes never overlap.
- The low storage bits are zero whenever the soft-reset bit is set.
- A drain-complete strobe is always followed by a set gate bit.
- The gate and soft-reset bits only fall after a replace or clear write.

The exact drain latency, the masking behaviour of each alias, and the return to running after the clear sequence can only be shown by the bench. It runs directed scenarios and long random write sequences and compares them against a model that tracks the drain count.

// File: rtl/srst_ctrl_pkg.sv
package srst_ctrl_pkg;
  typedef struct packed {
    logic wrFull;   // replace whole word
    logic wrSet;    // OR in write data
    logic wrClr;    // AND-NOT write data
    logic gateSet;  // drain finished, force clock gate
  } ctrlStrobe_t;
endpackage

// File: rtl/srst_ctrl_fsm.sv
module srst_ctrl_fsm
  import srst_ctrl_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int DRAIN_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              srActive,
  output ctrlStrobe_t       strb
);
  localparam int CNT_W = $clog2(DRAIN_CYCLES) + 1;
  localparam logic [CNT_W-1:0]  LAST     = CNT_W'(DRAIN_CYCLES - 1);
  localparam logic [ADDR_W-1:0] OFF_BASE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_SET  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_CLR  = ADDR_W'(8);

  logic [CNT_W-1:0] drainCnt;

  always_ff @(posedge clk) begin
    if (!rstN)              drainCnt <= '0;
    else if (!srActive)     drainCnt <= '0;
    else if (drainCnt != LAST) drainCnt <= drainCnt + 1'b1;
  end

  always_comb begin
    strb.wrFull  = busWe && (busAddr == OFF_BASE);
    strb.wrSet   = busWe && (busAddr == OFF_SET);
    strb.wrClr   = busWe && (busAddr == OFF_CLR);
    strb.gateSet = srActive && (drainCnt == LAST);
  end

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrFull, strb.wrSet, strb.wrClr}));

  // R9
  drain_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(srActive) |-> (drainCnt == '0));
endmodule

// File: rtl/srst_ctrl_dp.sv
module srst_ctrl_dp
  import srst_ctrl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] word,
  output logic              srActive,
  output logic              clkEnable,
  output logic              modReset
);
  localparam int SR_BIT   = DATA_W - 1;
  localparam int GATE_BIT = DATA_W - 2;
  localparam logic [DATA_W-1:0] LOW_MASK = {2'b00, {(DATA_W-2){1'b1}}};

  logic [DATA_W-1:0] wordQ, wordNxt;

  always_comb begin
    wordNxt = wordQ;
    if (strb.wrFull)      wordNxt = wrData;
    else if (strb.wrSet)  wordNxt = wordQ | wrData;
    else if (strb.wrClr)  wordNxt = wordQ & ~wrData;
    if (strb.gateSet)     wordNxt[GATE_BIT] = 1'b1;
    if (wordNxt[SR_BIT])  wordNxt = wordNxt & ~LOW_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) wordQ <= '0;
    else       wordQ <= wordNxt;
  end

  assign word      = wordQ;
  assign srActive  = wordQ[SR_BIT];
  assign modReset  = wordQ[SR_BIT];
  assign clkEnable = ~wordQ[GATE_BIT];

  // R6
  low_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordQ[SR_BIT] |-> ((wordQ & LOW_MASK) == '0));

  // R7
  hw_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.gateSet |=> wordQ[GATE_BIT]);

  // R4
  gate_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wordQ[GATE_BIT]) |-> $past(strb.wrFull || strb.wrClr));

  // R9
  sr_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wordQ[SR_BIT]) |-> $past(strb.wrFull || strb.wrClr));
endmodule

// File: rtl/srst_ctrl_reg.sv
module srst_ctrl_reg
  import srst_ctrl_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 4,
  parameter int DRAIN_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              clkEnable,
  output logic              modReset
);
  ctrlStrobe_t strb;
  logic        srActive;

  srst_ctrl_fsm #(.ADDR_W(ADDR_W), .DRAIN_CYCLES(DRAIN_CYCLES)) i_fsm (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .srActive(srActive), .strb(strb)
  );

  srst_ctrl_dp #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(busWdata),
    .word(busRdata), .srActive(srActive),
    .clkEnable(clkEnable), .modReset(modReset)
  );
endmodule

// File: tb/test_srst_ctrl_reg.sv
module test_srst_ctrl_reg;
  localparam int PERIOD = 10;
  localparam int DRAIN  = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        clkEnable, modReset;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] expWord = '0;
  int          expCnt = 0;

  srst_ctrl_reg #(.DATA_W(32), .ADDR_W(4), .DRAIN_CYCLES(DRAIN)) i_srst_ctrl_reg (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .clkEnable(clkEnable), .modReset(modReset)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [31:0] applyWrite(logic [31:0] cur, logic we,
                                             logic [3:0] a, logic [31:0] d);
    if (!we)         return cur;
    if (a == 4'h0)   return d;
    if (a == 4'h4)   return cur | d;
    if (a == 4'h8)   return cur & ~d;
    return cur;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkAll(string tag);
    chk({tag, " word"}, busRdata, expWord);
    chk({tag, " clkEnable"}, {31'd0, clkEnable}, {31'd0, ~expWord[30]});
    chk({tag, " modReset"}, {31'd0, modReset}, {31'd0, expWord[31]});
  endtask

  // called at a negedge; returns at the following negedge
  task automatic step(logic we, logic [3:0] a, logic [31:0] d);
    logic [31:0] nxt;
    busWe = we; busAddr = a; busWdata = d;
    @(posedge clk);
    nxt = applyWrite(expWord, we, a, d);
    if (expWord[31] && expCnt == DRAIN-1) nxt[30] = 1'b1;
    if (nxt[31]) nxt[29:0] = '0;
    if (!expWord[31])         expCnt = 0;
    else if (expCnt < DRAIN-1) expCnt++;
    expWord = nxt;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expWord = '0; expCnt = 0;
    chkAll("R1 reset");

    step(1, 4'h0, 32'h1234_5678);  chkAll("R2 full write");
    step(1, 4'h4, 32'h0000_8001);  chkAll("R3 set alias");
    chk("R3 set value", busRdata, 32'h1234_D679);
    step(1, 4'h8, 32'h0000_0278);  chkAll("R4 clear alias");
    chk("R4 clear value", busRdata, 32'h1234_D401);
    step(1, 4'hC, 32'hFFFF_FFFF);  chkAll("R5 unmapped");
    step(1, 4'h4, 32'h4000_0000);  chkAll("R8 gate by software");
    chk("R8 clkEnable low", {31'd0, clkEnable}, 32'd0);
    step(1, 4'h8, 32'h4000_0000);  chkAll("R8 gate cleared");

    // soft reset and drain
    step(1, 4'h4, 32'h8000_0000);  chkAll("R6 soft reset on");
    chk("R6 low bits cleared", busRdata & 32'h3FFF_FFFF, 32'd0);
    step(1, 4'h4, 32'h0000_FFFF);  chkAll("R6 low write ignored");
    chk("R6 low bits stay zero", busRdata & 32'h3FFF_FFFF, 32'd0);
    for (int i = 2; i < DRAIN; i++) begin
      step(0, 4'h0, 32'd0);
      chk("R7 gate not early", {31'd0, busRdata[30]}, 32'd0);
    end
    step(0, 4'h0, 32'd0);
    chk("R7 gate after drain", {31'd0, busRdata[30]}, 32'd1);
    chkAll("R7 drained");
    step(1, 4'h8, 32'h4000_0000);
    chk("R7 gate held in reset", {31'd0, busRdata[30]}, 32'd1);

    // release sequence
    step(1, 4'h8, 32'h8000_0000);  chkAll("R9 sr cleared");
    step(1, 4'h8, 32'h4000_0000);  chkAll("R9 gate cleared");
    chk("R9 running word", busRdata, 32'd0);
    chk("R9 clkEnable", {31'd0, clkEnable}, 32'd1);

    // restart drain
    step(1, 4'h0, 32'h8000_0000);
    for (int i = 1; i < DRAIN; i++) begin
      step(0, 4'h0, 32'd0);
      chk("R9 drain restarts", {31'd0, busRdata[30]}, 32'd0);
    end
    step(0, 4'h0, 32'd0);
    chk("R9 drain complete", {31'd0, busRdata[30]}, 32'd1);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] a;
      r = $urandom();
      a = 4'(($urandom() % 4) * 4);
      if ($urandom() % 4 != 0) r[31] = ($urandom() % 3 == 0);
      step($urandom() % 3 != 0, a, r);
      chkAll("R10 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule